// File: doc/BRIEF.md
# Burst Synchronous Static RAM

This block is a synthesizable model of a synchronous static RAM with a two-bit burst address counter. All control, address and write-data inputs are captured on the rising clock edge. A new access starts when either of two address strobes is asserted: one is meant for a processor and one for a memory controller. After that, a burst-advance input steps through the rest of an aligned group of four words. The burst can run in linear order or in interleaved order, where the offset is the start offset XOR a count.

Writes are selected at three levels. A global write enable writes every byte lane. A byte-write enable hands control to one write enable per lane. With neither active, the cycle is a read. Read data leaves through a single register in flow-through mode, or through a second output register in pipelined mode. The data output is qualified by an output-enable flag and only carries data during reads. A sleep input freezes the block, and the stored array contents are kept. The array depth is a parameter.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is high and after it falls, no burst is active and `dq_oe` is low until a read has been started.
- R2: A strobe cycle with `en_main_n`=0, `en_hi`=1 and `en_lo_n`=0 loads `addr_i` and accesses it. A strobe cycle with any of these enables inactive deselects the device: there is no access, any burst ends and `dq_oe` stays low.
- R3: When `en_main_n` is high, `strb_cpu_n` is ignored. With `strb_ctl_n` high, the cycle acts as if no strobe were present, so an active burst continues.
- R4: In a non-strobe cycle of an active burst, `adv_n`=0 steps the burst count by one, wrapping modulo 4. With `adv_n`=1 the same address is accessed again.
- R5: With `order_sel`=1, the low two address bits of the access are the start offset XOR the count, giving 1,0,3,2 from a start offset of 1.
- R6: With `order_sel`=0, the low two bits are the start offset plus the count, modulo 4, giving 1,2,3,0 from a start offset of 1. The upper address bits never change during a burst.
- R7: With `wr_all_n`=0, the cycle writes both lanes of `din`, whatever the values of `wr_byte_n` and `lane_wr_n`.
- R8: With `wr_all_n`=1 and `wr_byte_n`=0, a low bit of `lane_wr_n` writes that lane (bit 0 is `din[7:0]`, bit 1 is `din[15:8]`) and leaves the other lane unchanged. If no lane is enabled, or `wr_byte_n`=1, the cycle is a read.
- R9: With `flow_thru_n`=0, read data for an access sampled at edge k is on `dq_o` right after edge k.
- R10: With `flow_thru_n`=1, read data for an access sampled at edge k appears right after edge k+1, and `dq_oe` is low after edge k alone.
- R11: `dq_oe` is high only while `oe_n`=0 and the selected output stage holds read data. The stage after a write cycle never drives.
- R12: While `sleep`=1, no access or write takes place, the burst state is held and `dq_oe` is low. After `sleep` falls, the burst resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Word address, captured on a strobe cycle |
| din | input | LANES*LANE_W | Write data |
| strb_cpu_n | input | 1 | Processor address strobe, active low, gated by en_main_n |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| en_main_n | input | 1 | Master chip enable, active low |
| en_hi | input | 1 | Secondary chip enable, active high |
| en_lo_n | input | 1 | Secondary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write enable, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| flow_thru_n | input | 1 | 0 selects flow-through reads, 1 selects pipelined reads |
| order_sel | input | 1 | 1 selects interleaved burst order, 0 selects linear |
| sleep | input | 1 | Freeze accesses, keep contents |
| dq_o | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | Drive enable for dq_o |

## Verification
The bench aims at the burst wrap from offset 3 back to 0 in both orders. A counter that carried into the upper address bits, or that used the wrong order, would return a word from outside the group of four. It tries a processor strobe while the master enable is high during a burst; a design that honoured it would jump to the new address instead of continuing. It checks a byte write with one lane enabled and also with no lane enabled: a wrong decoder would corrupt the untouched byte or would turn the empty write into a write. It also checks the extra stage of pipelined reads and a write request made during sleep: a wrong design would show data one cycle early, or would change the array and lose the burst position.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_LOAD,
        CYC_STEP,
        CYC_HOLD
    } cyc_kind_e;

    typedef struct packed {
        logic               act;
        logic [BURST_W-1:0] cnt;
    } burst_st_t;

    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] cnt,
        input logic               interleave
    );
        return interleave ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/sbsram_burst_ctrl.sv
module sbsram_burst_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              en_main_n,
    input  logic              en_hi,
    input  logic              en_lo_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic              acc_o,
    output logic [ADDR_W-1:0] eff_addr_o
);

    burst_st_t         st_q, st_d;
    logic [ADDR_W-1:0] base_q;
    logic              cpu_go, ctl_go, start, chip_ok;
    cyc_kind_e         kind;

    always_comb begin
        cpu_go  = !strb_cpu_n && !en_main_n;
        ctl_go  = !strb_ctl_n;
        start   = cpu_go || ctl_go;
        chip_ok = !en_main_n && en_hi && !en_lo_n;

        if (sleep)         kind = CYC_IDLE;
        else if (start)    kind = chip_ok ? CYC_LOAD : CYC_IDLE;
        else if (st_q.act) kind = adv_n ? CYC_HOLD : CYC_STEP;
        else               kind = CYC_IDLE;

        st_d = st_q;
        case (kind)
            CYC_LOAD: begin
                st_d.act = 1'b1;
                st_d.cnt = '0;
            end
            CYC_STEP: st_d.cnt = st_q.cnt + BURST_W'(1);
            default:  ;
        endcase
        if (!sleep && start && !chip_ok) st_d.act = 1'b0;
    end

    always_comb begin
        if (kind == CYC_LOAD) eff_addr_o = addr_i;
        else eff_addr_o = {base_q[ADDR_W-1:BURST_W],
                           burst_offset(base_q[BURST_W-1:0], st_d.cnt, order_sel)};
    end

    assign acc_o = (kind != CYC_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            base_q <= '0;
        end else begin
            st_q <= st_d;
            if (kind == CYC_LOAD) base_q <= addr_i;
        end
    end

    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_STEP) |=> (st_q.cnt == $past(st_q.cnt) + BURST_W'(1))); // R4

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(st_q) && $stable(base_q))); // R12

    AST_CPU_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (!strb_cpu_n && en_main_n && strb_ctl_n && !sleep) |=> $stable(base_q)); // R3

endmodule

// File: rtl/sbsram_wr_decode.sv
module sbsram_wr_decode #(
    parameter int LANES = 2
) (
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lane_we,
    output logic             is_wr
);

    always_comb begin
        if (!wr_all_n)       lane_we = '1;
        else if (!wr_byte_n) lane_we = ~lane_wr_n;
        else                 lane_we = '0;
        is_wr = |lane_we;
    end

endmodule

// File: rtl/sbsram_lane.sv
module sbsram_lane #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata_q
);

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata_q <= mem[addr];
    end

endmodule

// File: rtl/sbsram_read_pipe.sv
module sbsram_read_pipe #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              flow_thru_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } stage_t;

    logic   s1_vld;
    stage_t s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld   <= 1'b0;
            s2_q.vld <= 1'b0;
        end else begin
            s1_vld   <= rd_i;
            s2_q.vld <= s1_vld && !sleep;
        end
        s2_q.data <= rdata_i;
    end

    always_comb begin
        if (flow_thru_n) begin
            dq_o  = s2_q.data;
            dq_oe = s2_q.vld && !oe_n && !sleep;
        end else begin
            dq_o  = rdata_i;
            dq_oe = s1_vld && !oe_n && !sleep;
        end
    end

    AST_FT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && !flow_thru_n) |-> $past(rd_i)); // R9

    AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && flow_thru_n) |-> $past(rd_i, 2)); // R10

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbsram_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              en_main_n,
    input  logic              en_hi,
    input  logic              en_lo_n,
    input  logic              adv_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              oe_n,
    input  logic              flow_thru_n,
    input  logic              order_sel,
    input  logic              sleep,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    logic              acc;
    logic [ADDR_W-1:0] eff_addr;
    logic [LANES-1:0]  lane_we;
    logic              is_wr;
    logic              rd;
    logic [DATA_W-1:0] rdata;

    sbsram_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sleep      (sleep),
        .addr_i     (addr_i),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .en_main_n  (en_main_n),
        .en_hi      (en_hi),
        .en_lo_n    (en_lo_n),
        .adv_n      (adv_n),
        .order_sel  (order_sel),
        .acc_o      (acc),
        .eff_addr_o (eff_addr)
    );

    sbsram_wr_decode #(.LANES(LANES)) u_wdec (
        .wr_all_n  (wr_all_n),
        .wr_byte_n (wr_byte_n),
        .lane_wr_n (lane_wr_n),
        .lane_we   (lane_we),
        .is_wr     (is_wr)
    );

    assign rd = acc && !is_wr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sbsram_lane #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk     (clk),
            .we      (acc && lane_we[g]),
            .re      (rd),
            .addr    (eff_addr),
            .wdata   (din[g*LANE_W +: LANE_W]),
            .rdata_q (rdata[g*LANE_W +: LANE_W])
        );
    end

    sbsram_read_pipe #(.DATA_W(DATA_W)) u_rpipe (
        .clk         (clk),
        .rst         (rst),
        .sleep       (sleep),
        .rd_i        (rd),
        .rdata_i     (rdata),
        .flow_thru_n (flow_thru_n),
        .oe_n        (oe_n),
        .dq_o        (dq_o),
        .dq_oe       (dq_oe)
    );

    AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (acc && is_wr) |=> !(dq_oe && !flow_thru_n)); // R11

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dq_oe); // R12

endmodule

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int DW    = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [AW-1:0] addr_i;
    logic [DW-1:0] din, dq_o;
    logic strb_cpu_n, strb_ctl_n, en_main_n, en_hi, en_lo_n, adv_n;
    logic wr_all_n, wr_byte_n, oe_n, flow_thru_n, order_sel, sleep, dq_oe;
    logic [1:0] lane_wr_n;

    int checks = 0;
    int failures = 0;

    logic [DW-1:0] shadow [DEPTH];
    logic          m_act, s1v, s2v;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    logic [DW-1:0] s1d, s2d;

    sync_burst_sram u_sync_burst_sram (
        .clk(clk), .rst(rst), .addr_i(addr_i), .din(din),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .en_main_n(en_main_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
        .adv_n(adv_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .lane_wr_n(lane_wr_n), .oe_n(oe_n), .flow_thru_n(flow_thru_n),
        .order_sel(order_sel), .sleep(sleep), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    function automatic logic [DW-1:0] fill_val(input int a);
        return {8'(a) ^ 8'h5A, 8'(a * 3 + 1)};
    endfunction

    function automatic logic [1:0] off(input logic [1:0] s, input logic [1:0] c, input logic ilv);
        return ilv ? (s ^ c) : (s + c);
    endfunction

    task automatic chk(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic start, ok, acc, wr;
        logic [1:0] we;
        logic [AW-1:0] ea;
        if (rst) begin
            m_act = 0; m_cnt = 0; m_base = 0; s1v = 0; s2v = 0;
            return;
        end
        if (sleep) begin
            s1v = 0; s2v = 0;
            return;
        end
        acc = 0; ea = '0;
        start = (!strb_cpu_n && !en_main_n) || !strb_ctl_n;
        ok = !en_main_n && en_hi && !en_lo_n;
        if (start) begin
            if (ok) begin
                m_base = addr_i; m_cnt = 0; m_act = 1; acc = 1; ea = addr_i;
            end else m_act = 0;
        end else if (m_act) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            acc = 1;
            ea = {m_base[AW-1:2], off(m_base[1:0], m_cnt, order_sel)};
        end
        we = !wr_all_n ? 2'b11 : (!wr_byte_n ? ~lane_wr_n : 2'b00);
        wr = |we;
        s2v = s1v; s2d = s1d;
        if (acc && wr) begin
            if (we[0]) shadow[ea][7:0]  = din[7:0];
            if (we[1]) shadow[ea][15:8] = din[15:8];
        end
        s1v = acc && !wr;
        if (s1v) s1d = shadow[ea];
    endtask

    task automatic auto_check();
        logic ev, eo;
        logic [DW-1:0] ed;
        ev = flow_thru_n ? s2v : s1v;
        ed = flow_thru_n ? s2d : s1d;
        eo = ev && !oe_n && !sleep;
        chk("R11", {dq_oe, 16'h0}, {eo, 16'h0});
        if (eo && dq_oe) chk(flow_thru_n ? "R10" : "R9", {1'b1, dq_o}, {1'b1, ed});
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        auto_check();
    endtask

    task automatic idle();
        strb_cpu_n = 1; strb_ctl_n = 1; en_main_n = 0; en_hi = 1; en_lo_n = 0;
        adv_n = 1; wr_all_n = 1; wr_byte_n = 1; lane_wr_n = 2'b11; sleep = 0;
    endtask

    task automatic load(input int a, input logic wr, input logic [DW-1:0] d);
        strb_ctl_n = 0; en_main_n = 0; en_hi = 1; en_lo_n = 0;
        addr_i = AW'(a); wr_all_n = !wr; din = d;
        tick();
        idle();
    endtask

    task automatic step();
        adv_n = 0;
        tick();
        adv_n = 1;
    endtask

    task automatic expect_word(input string tag, input int a);
        chk(tag, {dq_oe, dq_o}, {1'b1, fill_val(a)});
    endtask

    task automatic expect_off(input string tag);
        chk(tag, {dq_oe, 16'h0}, {1'b0, 16'h0});
    endtask

    task automatic drain();
        strb_ctl_n = 0; en_hi = 0;
        tick();
        idle();
        tick();
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] w;
        int unsigned r;
        idle();
        addr_i = '0; din = '0; oe_n = 0; flow_thru_n = 0; order_sel = 1;
        r = $urandom(32'd4711);
        repeat (3) tick();
        expect_off("R1");
        rst = 0;
        tick();
        expect_off("R1");

        for (int a = 0; a < DEPTH; a++) load(a, 1'b1, fill_val(a));
        tick();
        load(9, 1'b0, '0);
        expect_word("R7", 9);

        // interleaved burst from offset 1
        order_sel = 1;
        load(5, 1'b0, '0); expect_word("R2", 5);
        step(); expect_word("R5", 4);
        step(); expect_word("R5", 7);
        step(); expect_word("R5", 6);
        step(); expect_word("R5", 5);

        // linear burst from offset 1, hold, wrap
        order_sel = 0;
        load(5, 1'b0, '0); expect_word("R6", 5);
        step(); expect_word("R6", 6);
        step(); expect_word("R6", 7);
        step(); expect_word("R6", 4);
        tick(); expect_word("R4", 4);
        step(); expect_word("R4", 5);

        // deselect
        strb_ctl_n = 0; en_hi = 0; addr_i = 6'd10;
        tick(); expect_off("R2");
        idle(); tick(); expect_off("R2");
        strb_cpu_n = 0; en_lo_n = 1; addr_i = 6'd11;
        tick(); expect_off("R2");
        idle(); tick(); expect_off("R2");

        // processor strobe with master enable high
        load(12, 1'b0, '0); expect_word("R3", 12);
        strb_cpu_n = 0; en_main_n = 1; addr_i = 6'd40; adv_n = 0;
        tick(); expect_word("R3", 13);
        idle();

        // byte writes
        strb_ctl_n = 0; addr_i = 6'd20; wr_byte_n = 0; lane_wr_n = 2'b10; din = 16'hBEEF;
        tick(); expect_off("R11");
        idle(); tick();
        w = fill_val(20);
        chk("R8", {dq_oe, dq_o}, {1'b1, w[15:8], 8'hEF});
        strb_ctl_n = 0; addr_i = 6'd21; wr_byte_n = 0; lane_wr_n = 2'b11; din = 16'h0000;
        tick(); expect_word("R8", 21);
        idle();
        strb_ctl_n = 0; addr_i = 6'd23; wr_byte_n = 1; lane_wr_n = 2'b00; din = 16'h0000;
        tick(); expect_word("R8", 23);
        idle();
        strb_ctl_n = 0; addr_i = 6'd22; wr_all_n = 0; wr_byte_n = 0; lane_wr_n = 2'b11; din = 16'h1234;
        tick(); idle(); tick();
        chk("R7", {dq_oe, dq_o}, {1'b1, 16'h1234});

        // output enable gating
        load(9, 1'b0, '0);
        oe_n = 1; #1; expect_off("R11");
        oe_n = 0; #1; expect_word("R11", 9);

        // pipelined read
        drain();
        flow_thru_n = 1;
        load(33, 1'b0, '0); expect_off("R10");
        tick(); expect_word("R10", 33);
        drain();
        flow_thru_n = 0;

        // sleep
        load(8, 1'b0, '0); expect_word("R12", 8);
        sleep = 1; strb_ctl_n = 0; addr_i = 6'd3; wr_all_n = 0; din = 16'hDEAD; adv_n = 0;
        tick(); expect_off("R12");
        idle();
        step(); expect_word("R12", 9);
        load(3, 1'b0, '0); expect_word("R12", 3);

        // constrained random traffic checked against the model
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) order_sel = 1'($urandom);
            if (i % 400 == 0) flow_thru_n = 1'($urandom);
            r = $urandom;
            sleep      = (r[3:0] == 4'd0);
            strb_ctl_n = (r[6:4] != 3'd0);
            strb_cpu_n = (r[9:7] != 3'd0);
            en_main_n  = (r[13:10] == 4'd0);
            en_hi      = (r[17:14] != 4'd0);
            en_lo_n    = (r[21:18] == 4'd0);
            adv_n      = r[22];
            wr_all_n   = (r[25:23] != 3'd0);
            wr_byte_n  = r[26];
            lane_wr_n  = r[28:27];
            oe_n       = (r[31:29] == 3'd0);
            addr_i     = AW'($urandom);
            din        = DW'($urandom);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule